// File: doc/BRIEF.md
# Comparator Change Interrupt Logic

This block turns edges on a single comparator output into a sticky interrupt flag. The raw output first passes through a flop synchronizer. The synchronized value is then compared against a held copy. The held copy is refreshed only when software touches the comparator's status/control register, which is signalled by a one-cycle access strobe covering both reads and writes. While the live value and the held copy disagree, the flag is driven to 1 on every cycle. A change therefore cannot be lost, even if software clears the flag before it has accessed the status register.

Software controls the flag through a write port. Writing 0 clears the flag. Writing 1 raises a software-made interrupt. The interrupt request goes out only when the flag and all three enable bits are 1: the source enable, the peripheral-group enable and the global enable. The flag records changes whatever the enables are. A change that reaches the compare point in the same cycle as a register access is taken into the held copy and does not set the flag.

Top module: `cmp_chg_irq`

## Requirements
- R1: While reset is held low, and after it is released with the comparator input steady, flag, all enable bits and irq read 0. No flag is raised by reset itself.
- R2: A change on cmp_raw, with no register access, sets flag on the third rising clock edge after the change.
- R3: When software writes flag_wdata=0 while a mismatch is active and reg_access is low, flag stays 1, because a set takes priority over a clear in the same cycle.
- R4: A reg_access pulse loads the held copy with the synchronized value and ends the mismatch. A following write of 0 then clears flag.
- R5: flag is sticky. If cmp_raw returns to the held value, the flag stays 1. Only a write of 0 clears it.
- R6: Writing flag_wdata=1 with flag_we sets flag on the next edge, with no comparator change.
- R7: irq is 1 exactly when flag is 1 and en_q is 3'b111. Bit 0 is the source enable, bit 1 the peripheral-group enable and bit 2 the global enable. en_q loads en_wdata on an edge where en_we is 1.
- R8: A comparator change sets flag even while en_q is 0, and irq stays 0.
- R9: If a new synchronized value first differs from the held copy in a cycle where reg_access is 1, flag is not set. The held copy takes the new value, so no later mismatch follows.
- R10: cmp_status shows cmp_raw after two rising edges, through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_raw | input | 1 | Asynchronous comparator output |
| reg_access | input | 1 | One-cycle strobe for any read or write of the status/control register |
| flag_we | input | 1 | Write strobe for the interrupt flag |
| flag_wdata | input | 1 | Value written to the flag |
| en_we | input | 1 | Write strobe for the enable bits |
| en_wdata | input | 3 | Enable values: [0] source, [1] group, [2] global |
| cmp_status | output | 1 | Synchronized comparator output, readable status bit |
| flag | output | 1 | Sticky change-interrupt flag |
| en_q | output | 3 | Current enable bits |
| irq | output | 1 | Gated interrupt request |

## Verification
The bench clears the flag while a mismatch is still active. A design that lets the clear win, or that keeps no held copy, would drop the flag and lose the change. It also moves the comparator back to its held value after the flag is set, which catches a flag that follows the input rather than staying sticky. It lands a change on a register access cycle and watches several later cycles: a design without the race rule would set the flag, and one that skips the reload would set it a cycle later. Every one of the eight enable combinations is applied with the flag set, so a gate that misses any one enable term raises irq at least once.

// File: rtl/cmpi_pkg.sv
// Package: shared sizing for the comparator change interrupt block.
// Assumes exactly three enable levels, each at a fixed bit position.
package cmpi_pkg;
    localparam int EN_W       = 3;
    localparam int EN_SOURCE  = 0;
    localparam int EN_GROUP   = 1;
    localparam int EN_GLOBAL  = 2;
endpackage

// File: rtl/cmpi_sync.sv
// Module: flop chain that brings an asynchronous bit into the clk domain.
// Assumes STAGES >= 2. The chain is left without reset on purpose: it keeps
// sampling during reset, so the held copy can load a settled value.
module cmpi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d_async,
    output logic q_sync
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // purpose: capture the asynchronous input
                always_ff @(posedge clk) chain[0] <= d_async;
            end else begin : g_next
                // purpose: let a metastable value settle through one more flop
                always_ff @(posedge clk) chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign q_sync = chain[LAST];
endmodule

// File: rtl/cmpi_track.sv
// Module: held copy of the comparator value and the sticky change flag.
// Assumes live is already synchronized. A mismatch in a cycle with no
// register access sets the flag, and a set wins over a software clear.
module cmpi_track (
    input  logic clk,
    input  logic rst_n,
    input  logic live,
    input  logic access,
    input  logic flag_we,
    input  logic flag_wdata,
    output logic held_q,
    output logic flag_q
);
    logic mismatch;
    logic set_hit;

    // purpose: detect disagreement, with the access cycle absorbing a change
    always_comb begin
        mismatch = live ^ held_q;
        set_hit  = mismatch & ~access;
    end

    // purpose: reload the held copy on reset or on any register access
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= live;
        else if (access)
            held_q <= live;
    end

    // purpose: sticky flag, hardware set beats the software write
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_hit)
            flag_q <= 1'b1;
        else if (flag_we)
            flag_q <= flag_wdata;
    end
endmodule

// File: rtl/cmpi_gate.sv
// Module: enable register and interrupt gate.
// Assumes the request must have every enable bit set together with the flag.
module cmpi_gate #(
    parameter int EN_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_we,
    input  logic [EN_W-1:0] en_wdata,
    input  logic            flag_q,
    output logic [EN_W-1:0] en_q,
    output logic            irq
);
    // purpose: hold the enable bits written by software
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (en_we)
            en_q <= en_wdata;
    end

    // purpose: request only when the flag and all enables agree
    always_comb irq = flag_q & (&en_q);
endmodule

// File: rtl/cmp_chg_irq.sv
// Module: top of the comparator change interrupt logic.
// Assumes reg_access is a one-cycle strobe for any read or write of the
// status/control register, and that cmp_raw may change at any time.
module cmp_chg_irq
    import cmpi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmp_raw,
    input  logic            reg_access,
    input  logic            flag_we,
    input  logic            flag_wdata,
    input  logic            en_we,
    input  logic [EN_W-1:0] en_wdata,
    output logic            cmp_status,
    output logic            flag,
    output logic [EN_W-1:0] en_q,
    output logic            irq
);
    logic held_q;

    cmpi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .d_async (cmp_raw),
        .q_sync  (cmp_status)
    );

    cmpi_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .live       (cmp_status),
        .access     (reg_access),
        .flag_we    (flag_we),
        .flag_wdata (flag_wdata),
        .held_q     (held_q),
        .flag_q     (flag)
    );

    cmpi_gate #(.EN_W(EN_W)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_we    (en_we),
        .en_wdata (en_wdata),
        .flag_q   (flag),
        .en_q     (en_q),
        .irq      (irq)
    );
endmodule

// File: rtl/cmp_chg_irq_chk.sv
// Module: property checker, bound to every cmp_chg_irq instance.
// Assumes signal names that match the top, including the internal held_q.
module cmp_chg_irq_chk
    import cmpi_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            reg_access,
    input logic            flag_we,
    input logic            flag_wdata,
    input logic            cmp_status,
    input logic            held_q,
    input logic            flag,
    input logic [EN_W-1:0] en_q,
    input logic            irq
);
    // R2 / R3: a mismatch outside an access cycle leaves the flag set
    a_r2_mismatch_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_status != held_q && !reg_access) |=> flag);

    // R4 / R9: an access loads the synchronized value into the held copy
    a_r4_access_reloads: assert property (@(posedge clk) disable iff (!rst_n)
        reg_access |=> (held_q == $past(cmp_status)));

    // R5: with no software write the flag never falls
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_we) |=> flag);

    // R6: a written 1 always shows on the next cycle
    a_r6_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && flag_wdata) |=> flag);

    // R7: the request needs the flag and every enable bit
    a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && en_q == {EN_W{1'b1}}));

    // R9: an access with a clear flag and no soft set leaves the flag clear
    a_r9_race_absorbed: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_access && !flag && !(flag_we && flag_wdata)) |=> !flag);
endmodule

bind cmp_chg_irq cmp_chg_irq_chk u_chk (.*);

// File: tb/cmp_chg_irq_test.sv
// Directed bench for cmp_chg_irq. Inputs are driven and outputs sampled at
// falling edges. The design registers on rising edges.
module cmp_chg_irq_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_raw = 1'b0;
    logic       reg_access = 1'b0;
    logic       flag_we = 1'b0;
    logic       flag_wdata = 1'b0;
    logic       en_we = 1'b0;
    logic [2:0] en_wdata = 3'b000;
    logic       cmp_status;
    logic       flag;
    logic [2:0] en_q;
    logic       irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    cmp_chg_irq uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_raw    (cmp_raw),
        .reg_access (reg_access),
        .flag_we    (flag_we),
        .flag_wdata (flag_wdata),
        .en_we      (en_we),
        .en_wdata   (en_wdata),
        .cmp_status (cmp_status),
        .flag       (flag),
        .en_q       (en_q),
        .irq        (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic access_pulse();
        reg_access = 1'b1; step(); reg_access = 1'b0;
    endtask

    task automatic write_flag(input logic v);
        flag_we = 1'b1; flag_wdata = v; step(); flag_we = 1'b0;
    endtask

    task automatic write_en(input logic [2:0] v);
        en_we = 1'b1; en_wdata = v; step(); en_we = 1'b0;
    endtask

    // R1: reset state, and no flag once reset is released
    task automatic t_reset();
        rst_n = 1'b0; cmp_raw = 1'b0; step(4);
        chk("R1 flag in reset", flag, 0);
        chk("R1 en_q in reset", en_q, 0);
        chk("R1 irq in reset", irq, 0);
        rst_n = 1'b1; step(4);
        chk("R1 flag after release", flag, 0);
    endtask

    // R10 + R2: synchronizer latency and flag timing, then R4 clear
    task automatic t_change_latency();
        cmp_raw = 1'b1;
        step(); chk("R10 status after 1 edge", cmp_status, 0);
        chk("R2 flag after 1 edge", flag, 0);
        step(); chk("R10 status after 2 edges", cmp_status, 1);
        chk("R2 flag after 2 edges", flag, 0);
        step(); chk("R2 flag after 3 edges", flag, 1);
        access_pulse();
        write_flag(1'b0);
        chk("R4 clear after access", flag, 0);
        step(2); chk("R4 stays clear", flag, 0);
    endtask

    // R3: a clear during an active mismatch loses to the set
    task automatic t_persist();
        cmp_raw = 1'b0; step(3);
        chk("R3 flag raised", flag, 1);
        write_flag(1'b0);
        chk("R3 clear during mismatch", flag, 1);
        step(2); chk("R3 still set", flag, 1);
        access_pulse();
        write_flag(1'b0);
        chk("R4 clear after reload", flag, 0);
    endtask

    // R5: flag survives the comparator returning to the held value
    task automatic t_sticky();
        cmp_raw = 1'b1; step(3);
        chk("R5 flag raised", flag, 1);
        cmp_raw = 1'b0; step(4);
        chk("R5 flag kept after revert", flag, 1);
        write_flag(1'b0);
        chk("R5 cleared by write 0", flag, 0);
    endtask

    // R6: software set with no comparator activity
    task automatic t_soft_set();
        write_flag(1'b1);
        chk("R6 soft set", flag, 1);
        step(2); chk("R6 soft set held", flag, 1);
        write_flag(1'b0);
        chk("R6 soft clear", flag, 0);
    endtask

    // R8 and R7: flag independent of enables; irq needs every enable
    task automatic t_enables();
        write_en(3'b000);
        cmp_raw = 1'b1; step(3);
        chk("R8 flag with enables off", flag, 1);
        chk("R8 irq with enables off", irq, 0);
        access_pulse();
        for (int e = 0; e < 8; e++) begin
            write_en(3'(e));
            chk("R7 en_q written", en_q, e);
            chk("R7 irq gate", irq, (e == 7) ? 1 : 0);
        end
        write_flag(1'b0);
        chk("R7 irq drops with flag", irq, 0);
        write_en(3'b000);
    endtask

    // R9: change reaches compare point in the access cycle
    task automatic t_race();
        cmp_raw = 1'b0; step(2);
        chk("R9 status updated", cmp_status, 0);
        access_pulse();
        chk("R9 flag in race", flag, 0);
        step(4);
        chk("R9 no later flag", flag, 0);
        chk("R9 status held", cmp_status, 0);
    endtask

    initial begin
        t_reset();
        t_change_latency();
        t_persist();
        t_sticky();
        t_soft_set();
        t_enables();
        t_race();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule